// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front end for an external asynchronous static RAM of 32K words by 16 bits, split into a lower and an upper byte lane. A user issues one command at a time on a valid/ready request port. Each command carries a read/write flag, a word address, write data and one enable bit per byte lane. The controller then drives the memory's active-low chip enable, output enable, write enable and the two lane selects. It sequences each access as a fixed number of clock cycles.

Each timing window is a parameter given in nanoseconds, and the block converts it into whole clock cycles of at least one. For a write, the windows are address setup, write-enable pulse and hold. For a read, they are read wait and bus turnaround. The write data path has a separate output-enable signal for the pads. That signal is raised only while the write strobe is low and the memory's output enable is high, so the controller and the memory never drive the bus together. Read data is registered per lane, and a one-cycle response pulse marks both read data and write completion.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are all 1, and mem_dq_oe is 0.
- R2: A write keeps mem_ce_n low for setup, pulse and hold phases in that order: N_AS cycles with mem_we_n high, then N_WP cycles with mem_we_n low, then N_WH cycles with mem_we_n high; mem_oe_n stays high throughout.
- R3: mem_dq_oe is 1 only while mem_we_n is 0 and mem_oe_n is 1, and mem_dq_o then carries the command's write data.
- R4: req_be[0] controls mem_lb_n (data bits 7..0) and req_be[1] controls mem_ub_n (bits 15..8); during an access a lane select is low exactly when its enable bit is 1, so a one-lane write leaves the other lane's stored byte unchanged.
- R5: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for N_RW cycles; the bus is sampled in the last of them, and rsp_valid is 1 in the next cycle with rsp_rdata holding the sampled byte for enabled lanes and 0 for disabled lanes.
- R6: After a read, N_TA cycles pass with all memory controls high and req_ready 0 before req_ready returns to 1.
- R7: rsp_valid is a single-cycle pulse; for a write it appears in the first cycle after the hold phase, together with req_ready.
- R8: Each cycle count is ceil(time_ns / CLK_PERIOD_NS) with a minimum of 1; with CLK_PERIOD_NS = 4 and the default times this gives N_AS=1, N_WP=2, N_WH=1, N_RW=3, N_TA=2.
- R9: req_valid while req_ready is 0 has no effect: no access starts and nothing is written.
- R10: mem_addr, mem_lb_n and mem_ub_n stay constant for as long as mem_ce_n remains low.
- R11: A command with both enable bits 0 runs its full cycle with both lane selects high, writes nothing, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower, bit 1 upper |
| req_ready | output | 1 | Controller idle, command accepted when valid |
| rsp_valid | output | 1 | One-cycle completion / read data valid |
| rsp_rdata | output | 16 | Registered read data |
| mem_addr | output | 15 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_dq_o | output | 16 | Data toward the pads |
| mem_dq_oe | output | 1 | Pad output enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the pads |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is already in progress. The controller must not latch it, and the ongoing cycle must keep its address and lane selects. The bench accepts a read, then holds req_valid high with a conflicting write command for several cycles while the read wait and turnaround run. Afterwards it confirms that the read returned its own data and that the conflicting address still holds its original contents. One-lane writes stacked on a full-word write show that the untouched lane survives.

// File: rtl/sram_lane_pkg.sv
// Shared types and helpers for the SRAM byte-lane controller.
// Assumes: times are in whole nanoseconds and the clock period is nonzero.
package sram_lane_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RWAIT,
        PH_RTURN
    } phase_e;

    // Convert a time window to clock cycles, rounded up, never below one.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase of a memory access.
// Loading value N-1 on phase entry makes the phase last exactly N cycles;
// expired is high in the last cycle of the phase and while idle.
module sram_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_lane_io.sv
// Per-lane select generation, write data path and read capture.
// Assumes: be is stable for the whole access; cap pulses once per read.
module sram_lane_io #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [LANES-1:0] be,
    input  logic             drive,
    input  logic             cap,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    dq_i,
    output logic [LANES-1:0] sel_n,
    output logic [DW-1:0]    dq_o,
    output logic             dq_oe,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_q;

        assign sel_n[g] = ~(active & be[g]);

        // Capture this lane on the read strobe; a disabled lane reads zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (cap)
                lane_q <= be[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_q;
    end

    assign dq_o  = drive ? wdata : '0;
    assign dq_oe = drive;

endmodule

// File: rtl/sram_lane_ctrl.sv
// Synchronous controller for an asynchronous 16-bit SRAM with two byte lanes.
// Accepts one command in idle, sequences setup/pulse/hold for writes and
// wait/turnaround for reads, and pulses rsp_valid when done.
// Assumes: the external pad enables the data driver from mem_dq_oe.
module sram_lane_ctrl #(
    parameter int ADDR_W        = 15,
    parameter int LANE_W        = 8,
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ASETUP_NS   = 0,
    parameter int T_WPULSE_NS   = 7,
    parameter int T_WHOLD_NS    = 1,
    parameter int T_RWAIT_NS    = 10,
    parameter int T_TURN_NS     = 5,
    localparam int LANES        = 2,
    localparam int DATA_W       = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    import sram_lane_pkg::*;

    localparam int N_AS  = ns_to_cycles(T_ASETUP_NS, CLK_PERIOD_NS);
    localparam int N_WP  = ns_to_cycles(T_WPULSE_NS, CLK_PERIOD_NS);
    localparam int N_WH  = ns_to_cycles(T_WHOLD_NS,  CLK_PERIOD_NS);
    localparam int N_RW  = ns_to_cycles(T_RWAIT_NS,  CLK_PERIOD_NS);
    localparam int N_TA  = ns_to_cycles(T_TURN_NS,   CLK_PERIOD_NS);
    localparam int N_MAX = max_of(max_of(max_of(N_AS, N_WP), max_of(N_WH, N_RW)), N_TA);
    localparam int CW    = $clog2(N_MAX) + 1;

    phase_e            ph, ph_nxt;
    logic              tmr_load, tmr_done;
    logic [CW-1:0]     tmr_val;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  be_q;
    logic              rsp_q;
    logic              active, drive, cap;
    logic [LANES-1:0]  sel_n;

    sram_phase_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load),
        .load_val(tmr_val), .expired(tmr_done)
    );

    // Next-phase selection and timer reload on every phase entry.
    always_comb begin
        ph_nxt   = ph;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ph)
            PH_IDLE: if (req_valid) begin
                ph_nxt   = req_write ? PH_WSETUP : PH_RWAIT;
                tmr_load = 1'b1;
                tmr_val  = req_write ? CW'(N_AS - 1) : CW'(N_RW - 1);
            end
            PH_WSETUP: if (tmr_done) begin
                ph_nxt = PH_WPULSE; tmr_load = 1'b1; tmr_val = CW'(N_WP - 1);
            end
            PH_WPULSE: if (tmr_done) begin
                ph_nxt = PH_WHOLD; tmr_load = 1'b1; tmr_val = CW'(N_WH - 1);
            end
            PH_WHOLD: if (tmr_done) ph_nxt = PH_IDLE;
            PH_RWAIT: if (tmr_done) begin
                ph_nxt = PH_RTURN; tmr_load = 1'b1; tmr_val = CW'(N_TA - 1);
            end
            PH_RTURN: if (tmr_done) ph_nxt = PH_IDLE;
            default: ph_nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= PH_IDLE;
        else        ph <= ph_nxt;
    end

    // Latch the command when it is accepted in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0; addr_q <= '0; wdata_q <= '0; be_q <= '0;
        end else if (ph == PH_IDLE && req_valid) begin
            wr_q <= req_write; addr_q <= req_addr; wdata_q <= req_wdata; be_q <= req_be;
        end
    end

    // Completion pulse one cycle after the last hold or read-wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= 1'b0;
        else        rsp_q <= tmr_done && (ph == PH_WHOLD || ph == PH_RWAIT);
    end

    assign active = (ph != PH_IDLE) && (ph != PH_RTURN);
    assign drive  = (ph == PH_WPULSE) && wr_q;
    assign cap    = (ph == PH_RWAIT) && tmr_done;

    sram_lane_io #(.LANES(LANES), .LANE_W(LANE_W)) u_io (
        .clk(clk), .rst_n(rst_n), .active(active), .be(be_q),
        .drive(drive), .cap(cap), .wdata(wdata_q), .dq_i(mem_dq_i),
        .sel_n(sel_n), .dq_o(mem_dq_o), .dq_oe(mem_dq_oe), .rdata(rsp_rdata)
    );

    assign req_ready = (ph == PH_IDLE);
    assign rsp_valid = rsp_q;
    assign mem_addr  = addr_q;
    assign mem_ce_n  = ~active;
    assign mem_we_n  = ~(ph == PH_WPULSE);
    assign mem_oe_n  = ~(ph == PH_RWAIT);
    assign mem_lb_n  = sel_n[0];
    assign mem_ub_n  = sel_n[1];

    // Checker counter: length of the current write-enable low run.
    logic [CW:0] we_run;
    always_ff @(posedge clk) begin
        if (!rst_n)        we_run <= '0;
        else if (!mem_we_n) we_run <= we_run + 1'b1;
        else               we_run <= '0;
    end

    // R2
    wpulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run == (CW+1)'(N_WP)));
    // R2
    we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));
    // R3
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n));
    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |->
        ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));
    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R6
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural lane-aware SRAM model plus a per-cycle queue of expected
// control vectors, compared on every falling clock edge.
module sim_sram_lane_ctrl;

    localparam int PER = 4;   // period value given to the design for cycle math
    function automatic int cyc(input int t);
        int c; c = (t + PER - 1) / PER; return (c < 1) ? 1 : c;
    endfunction
    localparam int NAS = cyc(0), NWP = cyc(7), NWH = cyc(1), NRW = cyc(10), NTA = cyc(5);

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic req_ready, rsp_valid;
    logic [15:0] rsp_rdata, mem_dq_o, mem_dq_i;
    logic [14:0] mem_addr;
    logic mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit run = 0;

    always #10 clk = ~clk;

    sram_lane_ctrl #(.CLK_PERIOD_NS(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] mem [int];
    function automatic logic [15:0] rd(input int a);
        return mem.exists(a) ? mem[a] : (16'(a * 37) ^ 16'h5A5A);
    endfunction

    logic [15:0] cur;
    always_comb begin
        cur = rd(int'(mem_addr));
        mem_dq_i[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? cur[7:0]  : 8'hA5;
        mem_dq_i[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? cur[15:8] : 8'hA5;
    end

    // A lane is stored while chip enable, write enable and its select are low.
    always @(posedge clk) begin
        if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = rd(int'(mem_addr));
            if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
            mem[int'(mem_addr)] = w;
        end
    end

    // ---------------- expected control schedule ----------------
    typedef struct packed {
        logic ce, oe, we, lb, ub, drv, rdy, rsp, chkd;
        logic [15:0] data;
        logic [14:0] addr;
        logic [15:0] wd;
    } vec_t;
    vec_t q[$];

    function automatic vec_t mk(input logic [7:0] c, input logic k, input logic [15:0] d,
                                input logic [14:0] a, input logic [15:0] w);
        vec_t v;
        {v.ce, v.oe, v.we, v.lb, v.ub, v.drv, v.rdy, v.rsp} = c;
        v.chkd = k; v.data = d; v.addr = a; v.wd = w;
        return v;
    endfunction

    int we_len = 0, oe_len = 0;

    always @(negedge clk) begin
        if (rst_n && run) begin
            vec_t e;
            e = (q.size() > 0) ? q.pop_front() : mk(8'b11111010, 0, 0, 0, 0);
            // R1 R2 R5 R6 R7 control vector on every cycle
            chk("R2 R5 R6 R7 ctrl", {24'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n,
                                     mem_dq_oe, req_ready, rsp_valid},
                {24'd0, e.ce, e.oe, e.we, e.lb, e.ub, e.drv, e.rdy, e.rsp});
            if (!e.ce) chk("R10 address", 32'(mem_addr), 32'(e.addr));
            if (e.drv) chk("R3 write data", 32'(mem_dq_o), 32'(e.wd));
            if (e.chkd && e.rsp) chk("R5 read data", 32'(rsp_rdata), 32'(e.data));
            // R8 measured pulse widths
            if (!mem_we_n) we_len++;
            else if (we_len != 0) begin chk("R8 we width", we_len, NWP); we_len = 0; end
            if (!mem_oe_n) oe_len++;
            else if (oe_len != 0) begin chk("R8 read wait", oe_len, NRW); oe_len = 0; end
            // Handshake seen now: the access starts at the next rising edge.
            if (req_valid && req_ready) begin
                logic lb, ub;
                lb = ~req_be[0]; ub = ~req_be[1];
                if (req_write) begin
                    for (int i = 0; i < NAS; i++) q.push_back(mk({3'b011, lb, ub, 3'b000}, 0, 0, req_addr, req_wdata));
                    for (int i = 0; i < NWP; i++) q.push_back(mk({3'b010, lb, ub, 3'b100}, 0, 0, req_addr, req_wdata));
                    for (int i = 0; i < NWH; i++) q.push_back(mk({3'b011, lb, ub, 3'b000}, 0, 0, req_addr, req_wdata));
                    q.push_back(mk(8'b11111011, 0, 0, req_addr, 0));
                end else begin
                    logic [15:0] d, m;
                    m = rd(int'(req_addr));
                    d = {req_be[1] ? m[15:8] : 8'h00, req_be[0] ? m[7:0] : 8'h00};
                    for (int i = 0; i < NRW; i++) q.push_back(mk({3'b001, lb, ub, 3'b000}, 0, 0, req_addr, 0));
                    q.push_back(mk(8'b11111001, 1, d, req_addr, 0));
                    for (int i = 1; i < NTA; i++) q.push_back(mk(8'b11111000, 0, 0, req_addr, 0));
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL R7 watchdog: actual %0d cycles expected under 20000", cycles);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic w, input logic [14:0] a, input logic [15:0] d, input logic [1:0] b);
        logic acc;
        @(posedge clk); #2;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_be = b;
        do begin
            @(negedge clk); acc = req_ready;
            @(posedge clk);
        end while (!acc);
        #2 req_valid = 0;
    endtask

    task automatic wait_rsp(output logic [15:0] d);
        do @(negedge clk); while (!rsp_valid);
        d = rsp_rdata;
    endtask

    task automatic wr(input logic [14:0] a, input logic [15:0] d, input logic [1:0] b);
        logic [15:0] x;
        issue(1, a, d, b); wait_rsp(x);
    endtask

    task automatic rdw(input logic [14:0] a, input logic [1:0] b, output logic [15:0] d);
        issue(0, a, 0, b); wait_rsp(d);
    endtask

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 1);
        chk("R1 rsp", 32'(rsp_valid), 0);
        chk("R1 controls", {27'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 32'h1F);
        chk("R1 drive", 32'(mem_dq_oe), 0);
        run = 1;

        // R4 partial-lane writes keep the other lane
        wr(15'h0005, 16'hFFFF, 2'b11);
        wr(15'h0005, 16'h1234, 2'b01);
        rdw(15'h0005, 2'b11, r); chk("R4 lower-lane write", 32'(r), 32'h0000FF34);
        wr(15'h0005, 16'hAB00, 2'b10);
        rdw(15'h0005, 2'b11, r); chk("R4 upper-lane write", 32'(r), 32'h0000AB34);

        // R5 one-lane reads zero the disabled lane
        rdw(15'h0005, 2'b01, r); chk("R5 lower read", 32'(r), 32'h00000034);
        rdw(15'h0005, 2'b10, r); chk("R5 upper read", 32'(r), 32'h0000AB00);

        // R11 no lanes enabled
        wr(15'h0005, 16'h0000, 2'b00);
        rdw(15'h0005, 2'b11, r); chk("R11 write without lanes", 32'(r), 32'h0000AB34);
        rdw(15'h0005, 2'b00, r); chk("R11 read without lanes", 32'(r), 0);

        // Address boundaries
        wr(15'h7FFF, 16'hC3A5, 2'b11);
        wr(15'h0000, 16'h5AA5, 2'b11);
        rdw(15'h7FFF, 2'b11, r); chk("R2 top address", 32'(r), 32'h0000C3A5);
        rdw(15'h0000, 2'b11, r); chk("R2 bottom address", 32'(r), 32'h00005AA5);

        // R9 conflicting request held while a read is in progress
        issue(0, 15'h7FFF, 0, 2'b11);
        req_valid = 1; req_write = 1; req_addr = 15'h0100; req_wdata = 16'hDEAD; req_be = 2'b11;
        repeat (3) @(posedge clk);
        #2 req_valid = 0;
        wait_rsp(r); chk("R9 read during busy request", 32'(r), 32'h0000C3A5);
        rdw(15'h0100, 2'b11, r); chk("R9 ignored write address", 32'(r), 32'(16'(256 * 37) ^ 16'h5A5A));

        // Mixed pattern checked against the model store
        for (int i = 1; i < 9; i++) wr(15'(i * 273), 16'(i * 4661), 2'(i % 4));
        for (int i = 1; i < 9; i++) begin
            logic [15:0] init, e;
            init = 16'(i * 273 * 37) ^ 16'h5A5A;
            e = init;
            if (i % 4 == 1 || i % 4 == 3) e[7:0]  = 8'(i * 4661);
            if (i % 4 >= 2)               e[15:8] = 8'((i * 4661) >> 8);
            rdw(15'(i * 273), 2'b11, r); chk("R4 pattern", 32'(r), 32'(e));
        end

        repeat (8) @(posedge clk);
        chk("R6 back to idle", 32'(req_ready), 1);
        finish_run();
    end

endmodule